// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog

This block is a watchdog timer with one 32-bit control register. A write is guarded by a rotating key. While the stored enable bit is set, a write takes effect only when its key field is the bitwise inverse of the key already held. When no enable bit is stored, for example straight after reset, any write is taken.

Each accepted write does three things. It reloads a down-counter from the count field of the value stored before that write. It starts or stops the counter according to the new enable bit. It clears any escalation in progress. The counter moves one step per cycle in which the slow `tick` enable is high; in the intended system that is about 760 times a second. The first time the count runs out, the block raises `nmi`, loads a fixed grace count and keeps counting. If the grace count also runs out before software services the watchdog, the block pulses `rst_req` for one cycle and stops.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset `rd_data` is 0, `nmi` and `rst_req` are low and the counter is stopped, so ticks cause no event.
- R2: Field positions in the control word: key in bits [15:9] (7 bits), enable/command in bit 8, count taken as bits [8:0] of the stored word.
- R3: When stored bit 8 is 0, a write is accepted whatever its key, and `rd_data` then returns the written word.
- R4: When stored bit 8 is 1, a write whose bits [15:9] differ from the inverse of stored bits [15:9] is ignored: `rd_data`, `nmi` and the running count are unchanged.
- R5: An accepted write loads the counter with bits [8:0] of the word stored before it, and a value of 0 is loaded as 256.
- R6: An accepted write with bit 8 set starts the counter, and one with bit 8 clear stops it; a stopped counter ignores ticks.
- R7: A running counter loaded with N expires on the Nth tick after the write, and only on a tick.
- R8: On the first expiry `nmi` goes high, the counter reloads with 10 and keeps running.
- R9: An expiry after the first, with no service between, raises `rst_req` for exactly one cycle while `nmi` stays high, and the counter stops.
- R10: An accepted write drops `nmi`, cancels any pending reset escalation, and restarts the expiry sequence from the first stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 32 | Word to write |
| rd_data | output | 32 | Last accepted control word |
| tick | input | 1 | Count enable, one step per high cycle |
| nmi | output | 1 | Non-maskable interrupt after the first expiry |
| rst_req | output | 1 | One-cycle system reset request after the second expiry |

## Verification
Some rules hold on every cycle, and the assertions check these. They cover the accept and ignore decision for each write, the word read back after an accepted write, the one-cycle width of the reset request, the fact that a reset request only ever comes while `nmi` is high, and the fact that `nmi` only rises on a tick. Other behaviour builds up over hundreds of ticks, and only the bench scenarios can show it. This covers exact expiry times, the reload of 0 as 256, loading from the earlier word (bit 8 included), the 10-tick grace window and servicing within that window. The bench predicts the cycle of each interrupt and reset event and matches each one against what the design produces.

// File: rtl/keyed_watchdog.sv
`timescale 1ns/1ps
module keyed_watchdog #(
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 9,
  parameter int EN_BIT    = 8,
  parameter int KEY_LSB   = 9,
  parameter int KEY_W     = 7,
  parameter int GRACE     = 10,
  parameter int ZERO_LOAD = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              tick,
  output logic              nmi,
  output logic              rst_req
);
  localparam int KEY_MSB = KEY_LSB + KEY_W - 1;

  logic [DATA_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              run_q;
  logic [1:0]        hits_q;
  logic              nmi_q, rst_q;

  wire              locked   = ctrl_q[EN_BIT];
  wire              key_ok   = wr_data[KEY_MSB:KEY_LSB] == ~ctrl_q[KEY_MSB:KEY_LSB];
  wire              accept   = wr_en && (!locked || key_ok);
  wire [CNT_W-1:0]  old_cnt  = ctrl_q[CNT_W-1:0];
  wire [CNT_W-1:0]  load_val = (old_cnt == '0) ? CNT_W'(ZERO_LOAD) : old_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      hits_q <= 2'd0;
      nmi_q  <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      rst_q <= 1'b0;
      if (accept) begin
        ctrl_q <= wr_data;
        cnt_q  <= load_val;
        run_q  <= wr_data[EN_BIT];
        hits_q <= 2'd0;
        nmi_q  <= 1'b0;
      end else if (run_q && tick) begin
        if (cnt_q == CNT_W'(1)) begin
          if (hits_q == 2'd0) begin
            nmi_q  <= 1'b1;
            cnt_q  <= CNT_W'(GRACE);
            hits_q <= 2'd1;
          end else begin
            rst_q  <= 1'b1;
            run_q  <= 1'b0;
            hits_q <= 2'd2;
          end
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign rd_data = ctrl_q;
  assign nmi     = nmi_q;
  assign rst_req = rst_q;

  AST_LOCKED_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && rd_data[EN_BIT] && (wr_data[KEY_MSB:KEY_LSB] != ~rd_data[KEY_MSB:KEY_LSB])
    |=> $stable(rd_data)); // R4
  AST_ACCEPT_STORES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (!rd_data[EN_BIT] || (wr_data[KEY_MSB:KEY_LSB] == ~rd_data[KEY_MSB:KEY_LSB]))
    |=> rd_data == $past(wr_data) && !nmi && !rst_req); // R3 R10
  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req); // R9
  AST_RST_AFTER_NMI: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> nmi); // R9
  AST_NMI_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi) |-> $past(tick)); // R7
  AST_HITS_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    hits_q != 2'd3); // R9
  AST_COUNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> cnt_q != '0); // R5
endmodule

// File: tb/keyed_watchdog_test.sv
`timescale 1ns/1ps
module keyed_watchdog_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        tick = 1'b0;
  logic        nmi, rst_req;

  keyed_watchdog uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .tick(tick), .nmi(nmi), .rst_req(rst_req)
  );

  always #5 clk = ~clk;

  typedef struct { int kind; int cyc; string req; } ev_t;
  localparam int EV_NMI = 1;
  localparam int EV_RST = 2;
  ev_t q[$];
  int  cyc = 0;
  int  checks = 0;
  int  fails = 0;
  int  base = 0;
  bit  done = 1'b0;
  logic nmi_d = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] word(input logic [6:0] key, input logic en, input logic [7:0] cnt);
    return {16'd0, key, en, cnt};
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic push(input int kind, input int at, input string req);
    ev_t e;
    e.kind = kind; e.cyc = at; e.req = req;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if ((nmi && !nmi_d) || rst_req) begin
        int kind;
        kind = rst_req ? EV_RST : EV_NMI;
        if (q.size() == 0) begin
          check(1'b0, "unexpected event", kind, 0);
        end else begin
          ev_t e;
          e = q.pop_front();
          check(e.kind == kind && e.cyc == cyc, e.req, (kind << 24) | cyc, (e.kind << 24) | e.cyc);
        end
      end
      nmi_d <= nmi;
    end
  end

  task automatic write(input logic [31:0] v);
    wr_en = 1'b1; wr_data = v; tick = 1'b0;
    base = cyc + 1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(input int k);
    tick = 1'b1;
    repeat (k) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(rd_data == 32'd0, "R1 rd_data", rd_data, 0);
    check(nmi == 1'b0 && rst_req == 1'b0, "R1 outputs", {nmi, rst_req}, 0);
    run(300); // R1 stopped: no events expected

    // R3 R5 R8 R9: unlocked first write, old count 0 loads 256
    write(word(7'h15, 1'b1, 8'd5));
    check(rd_data == word(7'h15, 1'b1, 8'd5), "R3 readback", rd_data, word(7'h15, 1'b1, 8'd5));
    push(EV_NMI, base + 256, "R5 R8 first expiry at 256");
    push(EV_RST, base + 266, "R9 reset after grace 10");
    run(270);
    check(nmi == 1'b1, "R9 nmi held", nmi, 1);
    run(50); // R9 stopped after reset request

    // R4 locked write with wrong key ignored
    write(word(7'h15, 1'b0, 8'd3));
    check(rd_data == word(7'h15, 1'b1, 8'd5), "R4 ignored write", rd_data, word(7'h15, 1'b1, 8'd5));
    check(nmi == 1'b1, "R4 nmi unchanged", nmi, 1);

    // R2 R10 correct inverted key; load bits [8:0] of old word = 261
    write(word(7'h6A, 1'b1, 8'd20));
    check(rd_data == word(7'h6A, 1'b1, 8'd20), "R2 keyed readback", rd_data, word(7'h6A, 1'b1, 8'd20));
    check(nmi == 1'b0, "R10 nmi cleared", nmi, 0);
    run(100);
    write(word(7'h15, 1'b1, 8'd3)); // R10 service before expiry
    push(EV_NMI, base + 276, "R2 R5 load 0x114");
    push(EV_RST, base + 286, "R9 second reset");
    run(290);

    // R6 accepted write with bit 8 clear stops counting
    write(word(7'h6A, 1'b0, 8'd0));
    check(nmi == 1'b0, "R10 nmi cleared after reset", nmi, 0);
    run(400);
    check(nmi == 1'b0 && rst_req == 1'b0, "R6 stopped", {nmi, rst_req}, 0);

    // R3 unlocked again, any key; then small count R7
    write(word(7'h33, 1'b0, 8'd7));
    check(rd_data == word(7'h33, 1'b0, 8'd7), "R3 unlocked any key", rd_data, word(7'h33, 1'b0, 8'd7));
    write(word(7'h2A, 1'b1, 8'd0));
    push(EV_NMI, base + 7, "R7 expiry after 7 ticks");
    run(12);
    check(nmi == 1'b1, "R8 nmi during grace", nmi, 1);
    write(word(7'h55, 1'b0, 8'd0)); // R10 service in grace window
    check(nmi == 1'b0, "R10 grace service", nmi, 0);
    run(30);
    check(rst_req == 1'b0 && nmi == 1'b0, "R10 no reset after service", {nmi, rst_req}, 0);

    // R7 ticks gaps: no tick, no progress
    write(word(7'h11, 1'b0, 8'd4));
    write(word(7'h11, 1'b1, 8'd0));
    repeat (20) @(negedge clk);
    check(nmi == 1'b0, "R7 no tick no expiry", nmi, 0);
    push(EV_NMI, base + 24, "R7 expiry only on ticks");
    run(6);

    check(q.size() == 0, "all expected events seen", q.size(), 0);
    finish_run();
  end
endmodule